// File: doc/BRIEF.md
# Split-Transaction Bulk/Control Buffer

This block is the non-periodic half of the transaction translator inside a speed-translating hub. The high-speed side sends start-split requests for bulk and control transfers. Each carries a device address, endpoint number, direction, transfer type and one payload word. The block keeps each accepted request in a slot of a small multi-entry buffer. Storage for periodic traffic lives elsewhere and is not part of this block.

Stored requests go out on the full/low-speed side, one at a time and oldest first. A request is launched only while the periodic engine reports no pending work. The handshake and data that come back are kept in the slot until the host sends the matching complete-split, which collects the result and releases the slot. When the buffer is full, a start-split is refused with a NAK-style code and the host retries later, so progress follows the host's own flow control. A complete-split that arrives before the result exists receives a not-yet code. Requests are matched to slots by address, endpoint and direction.

Each high-speed request is answered exactly one clock later on the response port. The downstream side is a valid/ready command channel paired with a completion strobe.

Top module: `np_split_buffer`

## Requirements
- R1: While reset is asserted and directly after it, `hs_rsp_valid` and `ds_cmd_valid` are 0 and the buffer holds no entries.
- R2: A start-split (`hs_req_complete`=0) whose key (address, endpoint, direction) matches no held entry, arriving while a slot is free, is answered with code 0 (accepted). Up to DEPTH entries (at least 2) are held at the same time.
- R3: A start-split arriving while all DEPTH slots are occupied is answered with code 1 (full) and stores nothing; a later complete-split for that key gets code 5.
- R4: A start-split whose key equals a held entry's key is answered with code 2 (duplicate), and the held entry, including its payload, is left unchanged.
- R5: `ds_cmd_valid` is never 1 while `periodic_busy` is 1. A launched command carries the stored address, endpoint, direction, type and payload of its entry.
- R6: Waiting entries are launched in the order in which their start-splits were accepted.
- R7: At most one downstream transaction is in flight. From the cycle a command is taken (`ds_cmd_valid` and `ds_cmd_ready`) until `ds_done_valid` is seen, `ds_cmd_valid` stays 0.
- R8: A complete-split (`hs_req_complete`=1) that matches an entry whose result has not been recorded is answered with code 3 (not yet), and the entry is kept.
- R9: A complete-split that matches an entry holding a result is answered with code 4, the recorded handshake on `hs_rsp_hsk` (0 ACK, 1 NAK, 2 STALL, 3 error), and the entry is freed. A repeat complete-split for that key then gets code 5.
- R10: A complete-split that matches no held entry is answered with code 5 (unknown).
- R11: On a code 4 answer, `hs_rsp_data` carries the recorded data for an IN request (`hs_req_dir_in`=1) and is 0 for an OUT request. On all other codes `hs_rsp_hsk` and `hs_rsp_data` are 0.
- R12: The result is judged against entry state before the clock edge. A complete-split in the same cycle as the `ds_done_valid` for its entry gets code 3, and the next complete-split gets code 4.
- R13: `hs_rsp_valid` is 1 exactly in the cycle after each cycle with `hs_req_valid`=1, and the code is always one of 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_req_valid | input | 1 | High-speed request present this cycle |
| hs_req_complete | input | 1 | 0 = start-split, 1 = complete-split |
| hs_req_addr | input | ADDR_W | Device address |
| hs_req_ep | input | EP_W | Endpoint number |
| hs_req_dir_in | input | 1 | 1 = IN transfer, 0 = OUT |
| hs_req_ctl | input | 1 | 1 = control, 0 = bulk (start-split only) |
| hs_req_data | input | DATA_W | OUT payload word (start-split only) |
| hs_rsp_valid | output | 1 | Response present |
| hs_rsp_code | output | 3 | 0 accepted, 1 full, 2 duplicate, 3 not yet, 4 result, 5 unknown |
| hs_rsp_hsk | output | 2 | Recorded downstream handshake (code 4) |
| hs_rsp_data | output | DATA_W | Recorded IN data (code 4) |
| periodic_busy | input | 1 | Periodic engine has pending work |
| ds_cmd_valid | output | 1 | Downstream command offered |
| ds_cmd_ready | input | 1 | Downstream command taken |
| ds_cmd_addr | output | ADDR_W | Command device address |
| ds_cmd_ep | output | EP_W | Command endpoint |
| ds_cmd_dir_in | output | 1 | Command direction |
| ds_cmd_ctl | output | 1 | Command transfer type |
| ds_cmd_data | output | DATA_W | Command payload |
| ds_done_valid | input | 1 | Downstream transaction finished |
| ds_done_hsk | input | 2 | Handshake returned downstream |
| ds_done_data | input | DATA_W | Data returned downstream |

## Verification
The critical overlap is a complete-split for an entry arriving in the very clock in which the downstream side reports that entry's completion. The state before the edge must decide the answer, so the result is not handed out half-written. The bench produces this overlap on purpose: it holds a launched transaction's completion back until its latency has expired, then releases the completion strobe together with the complete-split. It expects code 3 first and code 4 with the recorded handshake on the following request. The random phase also produces start-splits that coincide with command hand-offs and completions, and a reference model of slot states and launch order judges each answer.

// File: rtl/npsb_pkg.sv
package npsb_pkg;

   // lifecycle of one buffer slot
   typedef enum logic [1:0] {
      SLOT_FREE = 2'd0,
      SLOT_WAIT = 2'd1,
      SLOT_LIVE = 2'd2,
      SLOT_DONE = 2'd3
   } slot_state_t;

   // answer codes on the high-speed side
   typedef enum logic [2:0] {
      RSP_TAKEN   = 3'd0,
      RSP_FULL    = 3'd1,
      RSP_DUP     = 3'd2,
      RSP_NOTYET  = 3'd3,
      RSP_RESULT  = 3'd4,
      RSP_UNKNOWN = 3'd5
   } rsp_code_t;

   localparam int HSK_W = 2;

endpackage

// File: rtl/npsb_slot_pick.sv
module npsb_slot_pick #(
   parameter int N         = 4,
   parameter bit PICK_HIGH = 1'b0,
   localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  free_vec,
   output logic          any_free,
   output logic [IW-1:0] pick_idx
);

   assign any_free = |free_vec;

   generate
      if (PICK_HIGH) begin : g_high
         always_comb begin
            pick_idx = '0;
            for (int i = 0; i < N; i++)
               if (free_vec[i]) pick_idx = IW'(i);
         end
      end else begin : g_low
         always_comb begin
            pick_idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (free_vec[i]) pick_idx = IW'(i);
         end
      end
   endgenerate

endmodule

// File: rtl/npsb_order_fifo.sv
module npsb_order_fifo #(
   parameter int N  = 4,
   parameter int IW = 2,
   localparam int CW = $clog2(N + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [IW-1:0] push_idx,
   input  logic          pop,
   output logic [IW-1:0] head_idx,
   output logic          empty
);

   logic [IW-1:0] mem_q [N];
   logic [IW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [IW-1:0] bump(input logic [IW-1:0] p);
      return (p == IW'(N - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= bump(wp_q);
         if (pop)  rp_q <= bump(rp_q);
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[wp_q] <= push_idx;
   end

   assign head_idx = mem_q[rp_q];
   assign empty    = (cnt_q == '0);

endmodule

// File: rtl/npsb_slot_table.sv
module npsb_slot_table
   import npsb_pkg::*;
#(
   parameter int N  = 4,
   parameter int IW = 2,
   parameter int AW = 7,
   parameter int EW = 4,
   parameter int DW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   // key lookup
   input  logic [AW-1:0]    key_addr,
   input  logic [EW-1:0]    key_ep,
   input  logic             key_dir_in,
   output logic             hit,
   output logic [IW-1:0]    hit_idx,
   output slot_state_t      hit_state,
   output logic [N-1:0]     free_vec,
   // fill a slot
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [AW-1:0]    wr_addr,
   input  logic [EW-1:0]    wr_ep,
   input  logic             wr_dir_in,
   input  logic             wr_ctl,
   input  logic [DW-1:0]    wr_data,
   // slot handed downstream
   input  logic             launch_en,
   input  logic [IW-1:0]    launch_idx,
   // result recorded
   input  logic             land_en,
   input  logic [IW-1:0]    land_idx,
   input  logic [HSK_W-1:0] land_hsk,
   input  logic [DW-1:0]    land_data,
   // slot released
   input  logic             drop_en,
   input  logic [IW-1:0]    drop_idx,
   // command read port
   input  logic [IW-1:0]    cmd_idx,
   output logic [AW-1:0]    cmd_addr,
   output logic [EW-1:0]    cmd_ep,
   output logic             cmd_dir_in,
   output logic             cmd_ctl,
   output logic [DW-1:0]    cmd_data,
   // result read port (at hit_idx)
   output logic [HSK_W-1:0] res_hsk,
   output logic [DW-1:0]    res_data
);

   slot_state_t      st_q   [N];
   logic [AW-1:0]    addr_q [N];
   logic [EW-1:0]    ep_q   [N];
   logic             dir_q  [N];
   logic             ctl_q  [N];
   logic [HSK_W-1:0] hsk_q  [N];
   // one word per slot: OUT payload until launch, returned data after landing
   logic [DW-1:0]    word_q [N];
   logic [N-1:0]     match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) st_q[i] <= SLOT_FREE;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (wr_en && wr_idx == IW'(i))
               st_q[i] <= SLOT_WAIT;
            else if (launch_en && launch_idx == IW'(i))
               st_q[i] <= SLOT_LIVE;
            else if (land_en && land_idx == IW'(i))
               st_q[i] <= SLOT_DONE;
            else if (drop_en && drop_idx == IW'(i))
               st_q[i] <= SLOT_FREE;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < N; i++) begin
         if (wr_en && wr_idx == IW'(i)) begin
            addr_q[i] <= wr_addr;
            ep_q[i]   <= wr_ep;
            dir_q[i]  <= wr_dir_in;
            ctl_q[i]  <= wr_ctl;
            word_q[i] <= wr_data;
            hsk_q[i]  <= '0;
         end else if (land_en && land_idx == IW'(i)) begin
            word_q[i] <= land_data;
            hsk_q[i]  <= land_hsk;
         end
      end
   end

   generate
      for (genvar g = 0; g < N; g++) begin : g_cmp
         assign free_vec[g] = (st_q[g] == SLOT_FREE);
         assign match[g]    = !free_vec[g] &&
                              (addr_q[g] == key_addr) &&
                              (ep_q[g] == key_ep) &&
                              (dir_q[g] == key_dir_in);
      end
   endgenerate

   always_comb begin
      hit_idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (match[i]) hit_idx = IW'(i);
   end

   assign hit       = |match;
   assign hit_state = st_q[hit_idx];
   assign res_hsk   = hsk_q[hit_idx];
   assign res_data  = word_q[hit_idx];

   assign cmd_addr   = addr_q[cmd_idx];
   assign cmd_ep     = ep_q[cmd_idx];
   assign cmd_dir_in = dir_q[cmd_idx];
   assign cmd_ctl    = ctl_q[cmd_idx];
   assign cmd_data   = word_q[cmd_idx];

endmodule

// File: rtl/np_split_buffer.sv
module np_split_buffer
   import npsb_pkg::*;
#(
   parameter int DEPTH     = 4,
   parameter int ADDR_W    = 7,
   parameter int EP_W      = 4,
   parameter int DATA_W    = 32,
   parameter bit PICK_HIGH = 1'b0,
   localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hs_req_valid,
   input  logic              hs_req_complete,
   input  logic [ADDR_W-1:0] hs_req_addr,
   input  logic [EP_W-1:0]   hs_req_ep,
   input  logic              hs_req_dir_in,
   input  logic              hs_req_ctl,
   input  logic [DATA_W-1:0] hs_req_data,
   output logic              hs_rsp_valid,
   output logic [2:0]        hs_rsp_code,
   output logic [1:0]        hs_rsp_hsk,
   output logic [DATA_W-1:0] hs_rsp_data,
   input  logic              periodic_busy,
   output logic              ds_cmd_valid,
   input  logic              ds_cmd_ready,
   output logic [ADDR_W-1:0] ds_cmd_addr,
   output logic [EP_W-1:0]   ds_cmd_ep,
   output logic              ds_cmd_dir_in,
   output logic              ds_cmd_ctl,
   output logic [DATA_W-1:0] ds_cmd_data,
   input  logic              ds_done_valid,
   input  logic [1:0]        ds_done_hsk,
   input  logic [DATA_W-1:0] ds_done_data
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("np_split_buffer: DEPTH must be 2 or more");
      end
      if (ADDR_W < 1 || EP_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("np_split_buffer: field widths must be positive");
      end
   endgenerate

   logic              hit, any_free;
   logic [IW-1:0]     hit_idx, pick_idx, head_idx;
   slot_state_t       hit_state;
   logic [DEPTH-1:0]  free_vec;
   logic              q_empty;
   logic [HSK_W-1:0]  res_hsk;
   logic [DATA_W-1:0] res_data;

   logic              take, drop, launch, land;
   rsp_code_t         code_d;
   logic              fly_q;
   logic [IW-1:0]     fly_idx_q;

   // high-speed request decode, judged on pre-edge slot state
   always_comb begin
      code_d = RSP_UNKNOWN;
      take   = 1'b0;
      drop   = 1'b0;
      if (hs_req_valid) begin
         if (!hs_req_complete) begin
            if (hit)
               code_d = RSP_DUP;
            else if (!any_free)
               code_d = RSP_FULL;
            else begin
               code_d = RSP_TAKEN;
               take   = 1'b1;
            end
         end else begin
            if (!hit)
               code_d = RSP_UNKNOWN;
            else if (hit_state == SLOT_DONE) begin
               code_d = RSP_RESULT;
               drop   = 1'b1;
            end else
               code_d = RSP_NOTYET;
         end
      end
   end

   // downstream side: one transaction at a time, yields to periodic work
   assign ds_cmd_valid = !q_empty && !fly_q && !periodic_busy;
   assign launch       = ds_cmd_valid && ds_cmd_ready;
   assign land         = ds_done_valid && fly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fly_q     <= 1'b0;
         fly_idx_q <= '0;
      end else if (launch) begin
         fly_q     <= 1'b1;
         fly_idx_q <= head_idx;
      end else if (land) begin
         fly_q     <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_rsp_valid <= 1'b0;
         hs_rsp_code  <= '0;
         hs_rsp_hsk   <= '0;
         hs_rsp_data  <= '0;
      end else begin
         hs_rsp_valid <= hs_req_valid;
         hs_rsp_code  <= code_d;
         hs_rsp_hsk   <= drop ? res_hsk : '0;
         hs_rsp_data  <= (drop && hs_req_dir_in) ? res_data : '0;
      end
   end

   npsb_slot_pick #(
      .N        (DEPTH),
      .PICK_HIGH(PICK_HIGH)
   ) u_pick (
      .free_vec(free_vec),
      .any_free(any_free),
      .pick_idx(pick_idx)
   );

   npsb_order_fifo #(
      .N (DEPTH),
      .IW(IW)
   ) u_order (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (take),
      .push_idx(pick_idx),
      .pop     (launch),
      .head_idx(head_idx),
      .empty   (q_empty)
   );

   npsb_slot_table #(
      .N (DEPTH),
      .IW(IW),
      .AW(ADDR_W),
      .EW(EP_W),
      .DW(DATA_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_addr  (hs_req_addr),
      .key_ep    (hs_req_ep),
      .key_dir_in(hs_req_dir_in),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .hit_state (hit_state),
      .free_vec  (free_vec),
      .wr_en     (take),
      .wr_idx    (pick_idx),
      .wr_addr   (hs_req_addr),
      .wr_ep     (hs_req_ep),
      .wr_dir_in (hs_req_dir_in),
      .wr_ctl    (hs_req_ctl),
      .wr_data   (hs_req_data),
      .launch_en (launch),
      .launch_idx(head_idx),
      .land_en   (land),
      .land_idx  (fly_idx_q),
      .land_hsk  (ds_done_hsk),
      .land_data (ds_done_data),
      .drop_en   (drop),
      .drop_idx  (hit_idx),
      .cmd_idx   (head_idx),
      .cmd_addr  (ds_cmd_addr),
      .cmd_ep    (ds_cmd_ep),
      .cmd_dir_in(ds_cmd_dir_in),
      .cmd_ctl   (ds_cmd_ctl),
      .cmd_data  (ds_cmd_data),
      .res_hsk   (res_hsk),
      .res_data  (res_data)
   );

endmodule

// File: rtl/npsb_checker.sv
module npsb_checker #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hs_req_valid,
   input logic              hs_req_dir_in,
   input logic              hs_rsp_valid,
   input logic [2:0]        hs_rsp_code,
   input logic [DATA_W-1:0] hs_rsp_data,
   input logic              periodic_busy,
   input logic              ds_cmd_valid,
   input logic              ds_cmd_ready,
   input logic [ADDR_W-1:0] ds_cmd_addr,
   input logic [DATA_W-1:0] ds_cmd_data,
   input logic              ds_done_valid
);

   // independent view of an outstanding downstream transaction
   logic seen_fly_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         seen_fly_q <= 1'b0;
      else if (ds_cmd_valid && ds_cmd_ready) seen_fly_q <= 1'b1;
      else if (ds_done_valid)             seen_fly_q <= 1'b0;
   end

   p_quiet_periodic_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ds_cmd_valid |-> !periodic_busy);

   p_one_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
      seen_fly_q |-> !ds_cmd_valid);

   p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_cmd_valid && !ds_cmd_ready) |=>
         (periodic_busy || (ds_cmd_valid && $stable(ds_cmd_addr) && $stable(ds_cmd_data))));

   p_rsp_follows_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hs_req_valid |=> hs_rsp_valid);

   p_rsp_only_after_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hs_rsp_valid |-> $past(hs_req_valid));

   p_code_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
      hs_rsp_valid |-> (hs_rsp_code <= 3'd5));

   p_out_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_rsp_valid && hs_rsp_code == 3'd4 && !$past(hs_req_dir_in)) |-> (hs_rsp_data == '0));

endmodule

bind np_split_buffer npsb_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_npsb_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hs_req_valid (hs_req_valid),
   .hs_req_dir_in(hs_req_dir_in),
   .hs_rsp_valid (hs_rsp_valid),
   .hs_rsp_code  (hs_rsp_code),
   .hs_rsp_data  (hs_rsp_data),
   .periodic_busy(periodic_busy),
   .ds_cmd_valid (ds_cmd_valid),
   .ds_cmd_ready (ds_cmd_ready),
   .ds_cmd_addr  (ds_cmd_addr),
   .ds_cmd_data  (ds_cmd_data),
   .ds_done_valid(ds_done_valid)
);

// File: tb/np_split_buffer_tb.sv
module np_split_buffer_tb;

   localparam int DEPTH = 4;
   localparam int AW    = 7;
   localparam int EW    = 4;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hs_req_valid = 1'b0, hs_req_complete = 1'b0;
   logic [AW-1:0] hs_req_addr = '0;
   logic [EW-1:0] hs_req_ep = '0;
   logic          hs_req_dir_in = 1'b0, hs_req_ctl = 1'b0;
   logic [DW-1:0] hs_req_data = '0;
   logic          hs_rsp_valid;
   logic [2:0]    hs_rsp_code;
   logic [1:0]    hs_rsp_hsk;
   logic [DW-1:0] hs_rsp_data;
   logic          periodic_busy = 1'b0;
   logic          ds_cmd_valid;
   logic          ds_cmd_ready = 1'b0;
   logic [AW-1:0] ds_cmd_addr;
   logic [EW-1:0] ds_cmd_ep;
   logic          ds_cmd_dir_in, ds_cmd_ctl;
   logic [DW-1:0] ds_cmd_data;
   logic          ds_done_valid = 1'b0;
   logic [1:0]    ds_done_hsk = '0;
   logic [DW-1:0] ds_done_data = '0;

   always #4 clk = ~clk;

   np_split_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .EP_W(EW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .hs_req_valid(hs_req_valid), .hs_req_complete(hs_req_complete),
      .hs_req_addr(hs_req_addr), .hs_req_ep(hs_req_ep), .hs_req_dir_in(hs_req_dir_in),
      .hs_req_ctl(hs_req_ctl), .hs_req_data(hs_req_data),
      .hs_rsp_valid(hs_rsp_valid), .hs_rsp_code(hs_rsp_code),
      .hs_rsp_hsk(hs_rsp_hsk), .hs_rsp_data(hs_rsp_data),
      .periodic_busy(periodic_busy),
      .ds_cmd_valid(ds_cmd_valid), .ds_cmd_ready(ds_cmd_ready),
      .ds_cmd_addr(ds_cmd_addr), .ds_cmd_ep(ds_cmd_ep), .ds_cmd_dir_in(ds_cmd_dir_in),
      .ds_cmd_ctl(ds_cmd_ctl), .ds_cmd_data(ds_cmd_data),
      .ds_done_valid(ds_done_valid), .ds_done_hsk(ds_done_hsk), .ds_done_data(ds_done_data)
   );

   int n_chk = 0, n_bad = 0;

   // reference model: 0 free, 1 waiting, 2 downstream, 3 result held
   int            m_st   [DEPTH];
   logic [AW-1:0] m_addr [DEPTH];
   logic [EW-1:0] m_ep   [DEPTH];
   logic          m_dir  [DEPTH];
   logic          m_ctl  [DEPTH];
   logic [DW-1:0] m_data [DEPTH];
   logic [1:0]    m_hsk  [DEPTH];
   int            m_q[$];
   bit            m_fly = 1'b0;
   int            m_fly_slot = 0;
   int            m_lat = 0;

   // stimulus knobs for the next cycle
   bit            k_req = 0, k_cpl = 0, k_dir = 0, k_ctl = 0;
   logic [AW-1:0] k_addr = '0;
   logic [EW-1:0] k_ep = '0;
   logic [DW-1:0] k_data = '0;
   bit            k_per = 0, k_rdy = 0, k_hold = 0;
   string         force_tag = "";

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic int m_find(logic [AW-1:0] a, logic [EW-1:0] e, logic d);
      for (int i = 0; i < DEPTH; i++)
         if (m_st[i] != 0 && m_addr[i] == a && m_ep[i] == e && m_dir[i] == d) return i;
      return -1;
   endfunction

   function automatic int m_free();
      for (int i = 0; i < DEPTH; i++)
         if (m_st[i] == 0) return i;
      return -1;
   endfunction

   // one clock: drive, check command side, predict, clock, check response
   task automatic step();
      bit            exp_cv, landing;
      int            hit, fs, head;
      logic [2:0]    e_code;
      logic [1:0]    e_hsk;
      logic [DW-1:0] e_data;
      string         e_tag;
      bit            e_v;
      periodic_busy   = k_per;
      hs_req_valid    = k_req;
      hs_req_complete = k_cpl;
      hs_req_addr     = k_addr;
      hs_req_ep       = k_ep;
      hs_req_dir_in   = k_dir;
      hs_req_ctl      = k_ctl;
      hs_req_data     = k_data;
      ds_done_valid   = 1'b0;
      #1;
      exp_cv = (m_q.size() > 0) && !m_fly && !k_per;
      chk(ds_cmd_valid == exp_cv, m_fly ? "R7" : "R5", "ds_cmd_valid",
          64'(ds_cmd_valid), 64'(exp_cv));
      if (exp_cv && ds_cmd_valid) begin
         head = m_q[0];
         chk(ds_cmd_addr == m_addr[head] && ds_cmd_ep == m_ep[head], "R6", "cmd key",
             64'({ds_cmd_addr, ds_cmd_ep}), 64'({m_addr[head], m_ep[head]}));
         chk(ds_cmd_dir_in == m_dir[head] && ds_cmd_ctl == m_ctl[head], "R5", "cmd dir/type",
             64'({ds_cmd_dir_in, ds_cmd_ctl}), 64'({m_dir[head], m_ctl[head]}));
         chk(ds_cmd_data == m_data[head], "R5", "cmd payload",
             64'(ds_cmd_data), 64'(m_data[head]));
      end
      ds_cmd_ready = k_rdy;
      landing = m_fly && (m_lat == 0) && !k_hold;
      if (landing) begin
         ds_done_valid = 1'b1;
         ds_done_hsk   = 2'($urandom_range(0, 3));
         ds_done_data  = m_dir[m_fly_slot] ? (m_data[m_fly_slot] ^ 32'h5A5A_0F0F)
                                           : ($urandom() | 32'h1);
      end
      // predicted answer from pre-edge state
      e_v = k_req; e_code = 3'd0; e_hsk = 2'd0; e_data = '0; e_tag = "R13";
      if (k_req) begin
         hit = m_find(k_addr, k_ep, k_dir);
         if (!k_cpl) begin
            if (hit >= 0) begin e_code = 3'd2; e_tag = "R4"; end
            else begin
               fs = m_free();
               if (fs < 0) begin e_code = 3'd1; e_tag = "R3"; end
               else begin
                  e_code = 3'd0; e_tag = "R2";
                  m_st[fs] = 1; m_addr[fs] = k_addr; m_ep[fs] = k_ep; m_dir[fs] = k_dir;
                  m_ctl[fs] = k_ctl; m_data[fs] = k_data;
                  m_q.push_back(fs);
               end
            end
         end else begin
            if (hit < 0) begin e_code = 3'd5; e_tag = "R10"; end
            else if (m_st[hit] == 3) begin
               e_code = 3'd4; e_tag = "R9"; e_hsk = m_hsk[hit];
               e_data = m_dir[hit] ? m_data[hit] : '0;
               m_st[hit] = 0;
            end else begin e_code = 3'd3; e_tag = "R8"; end
         end
      end
      if (force_tag != "") e_tag = force_tag;
      // downstream effects at this edge
      if (landing) begin
         m_fly = 1'b0;
         m_st[m_fly_slot] = 3;
         m_hsk[m_fly_slot] = ds_done_hsk;
         m_data[m_fly_slot] = ds_done_data;
      end else if (m_fly && m_lat > 0) begin
         m_lat--;
      end
      if (exp_cv && k_rdy) begin
         head = m_q.pop_front();
         m_st[head] = 2;
         m_fly = 1'b1;
         m_fly_slot = head;
         m_lat = $urandom_range(0, 3);
      end
      @(posedge clk);
      @(negedge clk);
      chk(hs_rsp_valid == e_v, "R13", "hs_rsp_valid", 64'(hs_rsp_valid), 64'(e_v));
      if (e_v && hs_rsp_valid) begin
         chk(hs_rsp_code == e_code, e_tag, "hs_rsp_code", 64'(hs_rsp_code), 64'(e_code));
         chk(hs_rsp_hsk == e_hsk, (e_code == 3'd4) ? "R9" : "R11", "hs_rsp_hsk",
             64'(hs_rsp_hsk), 64'(e_hsk));
         chk(hs_rsp_data == e_data, "R11", "hs_rsp_data", 64'(hs_rsp_data), 64'(e_data));
      end
      k_req = 0;
      force_tag = "";
   endtask

   task automatic start(input logic [AW-1:0] a, input logic [EW-1:0] e, input bit d,
                        input bit c, input logic [DW-1:0] p);
      k_req = 1; k_cpl = 0; k_addr = a; k_ep = e; k_dir = d; k_ctl = c; k_data = p;
      step();
   endtask

   task automatic collect(input logic [AW-1:0] a, input logic [EW-1:0] e, input bit d);
      k_req = 1; k_cpl = 1; k_addr = a; k_ep = e; k_dir = d; k_ctl = 0; k_data = 32'hDEAD_0000;
      step();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(hs_rsp_valid == 1'b0, "R1", "hs_rsp_valid in reset", 64'(hs_rsp_valid), 64'd0);
      chk(ds_cmd_valid == 1'b0, "R1", "ds_cmd_valid in reset", 64'(ds_cmd_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hs_rsp_valid == 1'b0, "R1", "hs_rsp_valid after reset", 64'(hs_rsp_valid), 64'd0);
      chk(ds_cmd_valid == 1'b0, "R1", "ds_cmd_valid after reset", 64'(ds_cmd_valid), 64'd0);
      force_tag = "R1";
      collect(7'd9, 4'd1, 1'b1);

      // fill while periodic work blocks launches (R2, R5)
      k_per = 1; k_rdy = 1;
      start(7'd1, 4'd1, 1'b1, 1'b0, 32'h1111_0001);
      start(7'd2, 4'd2, 1'b0, 1'b1, 32'h2222_0002);
      start(7'd3, 4'd3, 1'b1, 1'b1, 32'h3333_0003);
      start(7'd4, 4'd4, 1'b0, 1'b0, 32'h4444_0004);
      start(7'd5, 4'd5, 1'b1, 1'b0, 32'h5555_0005);   // R3 full
      force_tag = "R3";
      collect(7'd5, 4'd5, 1'b1);                       // nothing was stored
      start(7'd2, 4'd2, 1'b0, 1'b0, 32'hBAD0_BAD0);   // R4 duplicate
      collect(7'd1, 4'd1, 1'b1);                       // R8 not yet
      idle(3);

      // release: launches in acceptance order (R6), first one held back
      k_per = 0; k_hold = 1;
      idle(5);
      k_hold = 0;
      force_tag = "R12";
      collect(7'd1, 4'd1, 1'b1);                       // done and collect collide
      force_tag = "R12";
      collect(7'd1, 4'd1, 1'b1);
      idle(25);
      collect(7'd2, 4'd2, 1'b0);                       // OUT: data zero (R11)
      collect(7'd3, 4'd3, 1'b1);
      collect(7'd4, 4'd4, 1'b0);
      collect(7'd4, 4'd4, 1'b0);                       // R9 freed -> unknown
      start(7'd5, 4'd5, 1'b1, 1'b0, 32'h5555_0055);
      idle(10);
      collect(7'd5, 4'd5, 1'b1);

      // constrained random phase
      for (int n = 0; n < 3000; n++) begin
         k_per  = ($urandom_range(0, 3) == 0);
         k_rdy  = ($urandom_range(0, 3) != 0);
         k_hold = ($urandom_range(0, 4) == 0);
         if ($urandom_range(0, 2) != 0) begin
            k_req  = 1;
            k_cpl  = $urandom_range(0, 1) == 1;
            k_addr = AW'($urandom_range(1, 3));
            k_ep   = EW'($urandom_range(0, 1));
            k_dir  = $urandom_range(0, 1) == 1;
            k_ctl  = $urandom_range(0, 1) == 1;
            k_data = $urandom();
         end
         step();
      end
      k_per = 0; k_rdy = 1; k_hold = 0;
      idle(30);
      finish_run();
   end

endmodule